// File: doc/BRIEF.md
# Push-Button Volume Knob Register

This block keeps an 8-bit volume knob value that three front-panel buttons (up, down and mute) change. A mute flag lives in bit 7 and a 6-bit level in bits 5:0. The button inputs arrive already decoded and active high. Each one is filtered by its own debounce counter, and only a clean press edge produces an event. The level moves one step per press and stops at both ends of its range. The mute flag flips on each press of the mute button. Pressing up and down together also flips mute, and the level does not change.

The value is only held and reported. Software reads it on `knob_o` and applies it to the gain stages itself. Software can also overwrite the value through a one-cycle write strobe. A mode input gives the shared button pin to general-purpose I/O use, and while it is set the buttons leave the value alone. A lone up or down press only counts as a step after a pairing window equal to the debounce length has passed. This lets the block tell a two-button chord apart from two separate presses.

Top module: `vol_knob_ctrl`

## Requirements
- R1: After reset, and while reset is held, `knob_o` reads 0x00: unmuted at level 0.
- R2: A debounced press of up raises the level in bits 5:0 by one step.
- R3: A debounced press of down lowers the level in bits 5:0 by one step.
- R4: The level saturates. Up at 0x3F and down at 0x00 leave it unchanged, and it never wraps.
- R5: A debounced press of mute inverts bit 7 and leaves the level as it was.
- R6: If up and down are both debounced as pressed within one debounce window of each other, bit 7 inverts once and the level does not change.
- R7: A button input must stay at its new value for DEBOUNCE_CYCLES consecutive cycles before it counts. Shorter pulses do nothing, and a held button gives one step only, with no auto-repeat.
- R8: While `gpio_mode_i` is 1, button activity has no effect on `knob_o`.
- R9: A write (`wr_en_i`=1) loads `wr_data_i` into `knob_o` on the next cycle, with bit 6 forced to 0. A write takes priority over a button event that lands on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_i | input | 1 | Up button, active high |
| btn_dn_i | input | 1 | Down button, active high |
| btn_mute_i | input | 1 | Mute button, active high |
| gpio_mode_i | input | 1 | 1 = shared pin used as general-purpose I/O; buttons ignored |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write value |
| knob_o | output | 8 | Knob value: bit 7 mute, bit 6 zero, bits 5:0 level |

## Verification
The level is swept with 70 up presses from 0 and then 70 down presses. Each result is compared with a clamped count, which shows both single steps and the stop at each end. Pulse trains shorter than the debounce length and a long hold tell a filtered press apart from bounce and from auto-repeat. Chords are pressed with offsets of zero, two and ten cycles, which separates a mute toggle from two independent steps. A write is placed on the exact cycle a step lands to show which one wins, and presses are repeated with the general-purpose I/O mode set.

// File: rtl/vk_pkg.sv
package vk_pkg;
  localparam int KNOB_W  = 8;
  localparam int LEVEL_W = 6;
  localparam int MUTE_BIT = 7;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_UP   = 2'd1,
    PEND_DN   = 2'd2
  } pend_e;

  typedef struct packed {
    logic step_up;
    logic step_dn;
    logic toggle;
  } knob_ev_t;
endpackage

// File: rtl/vk_debounce.sv
module vk_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      if (raw_i == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        level_o <= raw_i;
        rise_o  <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vk_pair_arbiter.sv
module vk_pair_arbiter
  import vk_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic up_rise_i,
  input  logic dn_rise_i,
  output logic step_up_o,
  output logic step_dn_o,
  output logic pair_tog_o
);
  localparam int WIN_W = (WINDOW < 2) ? 1 : $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  pend_e            pend_q;
  logic [WIN_W-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= PEND_NONE;
      wcnt_q     <= '0;
      step_up_o  <= 1'b0;
      step_dn_o  <= 1'b0;
      pair_tog_o <= 1'b0;
    end else begin
      step_up_o  <= 1'b0;
      step_dn_o  <= 1'b0;
      pair_tog_o <= 1'b0;
      if (up_rise_i && dn_rise_i) begin
        pair_tog_o <= 1'b1;
        pend_q     <= PEND_NONE;
      end else if ((pend_q == PEND_UP && dn_rise_i) ||
                   (pend_q == PEND_DN && up_rise_i)) begin
        pair_tog_o <= 1'b1;
        pend_q     <= PEND_NONE;
      end else if (pend_q != PEND_NONE) begin
        if (wcnt_q == WIN_LAST) begin
          step_up_o <= (pend_q == PEND_UP);
          step_dn_o <= (pend_q == PEND_DN);
          pend_q    <= PEND_NONE;
          wcnt_q    <= '0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end else if (up_rise_i) begin
        pend_q <= PEND_UP;
        wcnt_q <= '0;
      end else if (dn_rise_i) begin
        pend_q <= PEND_DN;
        wcnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/vk_knob_reg.sv
module vk_knob_reg
  import vk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gpio_mode_i,
  input  logic              wr_en_i,
  input  logic [KNOB_W-1:0] wr_data_i,
  input  knob_ev_t          ev_i,
  output logic [KNOB_W-1:0] knob_o
);
  localparam logic [LEVEL_W-1:0] LVL_MAX = '1;
  localparam logic [LEVEL_W-1:0] LVL_MIN = '0;
  localparam int PAD_W = KNOB_W - 1 - LEVEL_W;

  logic               mute_q;
  logic [LEVEL_W-1:0] level_q;
  logic               btn_live;

  assign btn_live = !gpio_mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_q  <= 1'b0;
      level_q <= '0;
    end else if (wr_en_i) begin
      mute_q  <= wr_data_i[MUTE_BIT];
      level_q <= wr_data_i[LEVEL_W-1:0];
    end else if (btn_live) begin
      mute_q <= mute_q ^ ev_i.toggle;
      if (ev_i.step_up && level_q != LVL_MAX)
        level_q <= level_q + 1'b1;
      else if (ev_i.step_dn && level_q != LVL_MIN)
        level_q <= level_q - 1'b1;
    end
  end

  assign knob_o = {mute_q, {PAD_W{1'b0}}, level_q};
endmodule

// File: rtl/vol_knob_ctrl.sv
module vol_knob_ctrl
  import vk_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_up_i,
  input  logic       btn_dn_i,
  input  logic       btn_mute_i,
  input  logic       gpio_mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] knob_o
);
  localparam int NUM_BTN = 3;
  localparam int IDX_UP = 0;
  localparam int IDX_DN = 1;
  localparam int IDX_MUTE = 2;

  logic [NUM_BTN-1:0] raw;
  logic [NUM_BTN-1:0] held;
  logic [NUM_BTN-1:0] rise;
  logic               step_up, step_dn, pair_tog;
  knob_ev_t           ev;

  assign raw = {btn_mute_i, btn_dn_i, btn_up_i};

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_deb
    vk_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw[g]),
      .level_o(held[g]),
      .rise_o (rise[g])
    );
  end

  vk_pair_arbiter #(.WINDOW(DEBOUNCE_CYCLES)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .up_rise_i (rise[IDX_UP]),
    .dn_rise_i (rise[IDX_DN]),
    .step_up_o (step_up),
    .step_dn_o (step_dn),
    .pair_tog_o(pair_tog)
  );

  assign ev.step_up = step_up;
  assign ev.step_dn = step_dn;
  assign ev.toggle  = pair_tog ^ rise[IDX_MUTE];

  vk_knob_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .gpio_mode_i(gpio_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .ev_i       (ev),
    .knob_o     (knob_o)
  );

  logic unused_held;
  assign unused_held = ^held;
endmodule

// File: rtl/vol_knob_ctrl_chk.sv
module vol_knob_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       gpio_mode_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] knob_o
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> knob_o == 8'h00);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> (knob_o[5:0] == $past(knob_o[5:0]) ||
                  knob_o[5:0] == $past(knob_o[5:0]) + 6'd1 ||
                  knob_o[5:0] == $past(knob_o[5:0]) - 6'd1));

  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && knob_o[5:0] == 6'h3F) |=> knob_o[5:0] != 6'h00);

  assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && knob_o[5:0] == 6'h00) |=> knob_o[5:0] != 6'h3F);

  assert_gpio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (gpio_mode_i && !wr_en_i) |=> $stable(knob_o));

  assert_write_load_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> knob_o == {$past(wr_data_i[7]), 1'b0, $past(wr_data_i[5:0])});
endmodule

bind vol_knob_ctrl vol_knob_ctrl_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .gpio_mode_i(gpio_mode_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .knob_o     (knob_o)
);

// File: tb/test_vol_knob_ctrl.sv
module test_vol_knob_ctrl;
  localparam int DEB = 4;
  localparam int SETTLE = 3 * DEB + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up = 1'b0, dn = 1'b0, mu = 1'b0, gpio = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] knob;

  int n_tests = 0;
  int n_fail = 0;
  int exp_lvl = 0;
  logic exp_mute = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vol_knob_ctrl #(.DEBOUNCE_CYCLES(DEB)) i_vol_knob_ctrl (
    .clk(clk), .rst(rst), .btn_up_i(up), .btn_dn_i(dn), .btn_mute_i(mu),
    .gpio_mode_i(gpio), .wr_en_i(wr), .wr_data_i(wdata), .knob_o(knob)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: knob=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model();
    return {exp_mute, 1'b0, 6'(exp_lvl)};
  endfunction

  task automatic press(input int which);
    if (which == 0) up = 1'b1; else if (which == 1) dn = 1'b1; else mu = 1'b1;
    tick(SETTLE);
    up = 1'b0; dn = 1'b0; mu = 1'b0;
    tick(SETTLE);
  endtask

  task automatic press_pair(input int gap);
    up = 1'b1;
    tick(gap);
    dn = 1'b1;
    tick(SETTLE + 2 * DEB);
    up = 1'b0; dn = 1'b0;
    tick(SETTLE);
  endtask

  initial begin
    tick(3);
    check("R1 reset held", knob, 8'h00);
    rst = 1'b0;
    tick(2);
    check("R1 after reset", knob, 8'h00);

    // R2 and R4 sweep up past the top
    for (int i = 0; i < 70; i++) begin
      press(0);
      exp_lvl = (exp_lvl < 63) ? exp_lvl + 1 : 63;
      check((i < 63) ? "R2 up step" : "R4 top saturate", knob, model());
    end
    // R3 and R4 sweep down past the bottom
    for (int i = 0; i < 70; i++) begin
      press(1);
      exp_lvl = (exp_lvl > 0) ? exp_lvl - 1 : 0;
      check((i < 63) ? "R3 down step" : "R4 bottom saturate", knob, model());
    end

    for (int i = 0; i < 5; i++) begin press(0); exp_lvl++; end
    check("R2 level 5", knob, model());

    // R5 mute toggles and keeps level
    press(2); exp_mute = ~exp_mute;
    check("R5 mute on", knob, model());
    press(2); exp_mute = ~exp_mute;
    check("R5 mute off", knob, model());

    // R6 chords
    press_pair(0); exp_mute = ~exp_mute;
    check("R6 chord gap 0", knob, model());
    press_pair(2); exp_mute = ~exp_mute;
    check("R6 chord gap 2", knob, model());
    press_pair(DEB + 6);
    check("R6 separate presses net zero", knob, model());

    // R7 bounce shorter than debounce
    for (int i = 0; i < 10; i++) begin
      up = 1'b1; tick(DEB - 1); up = 1'b0; tick(DEB - 1);
    end
    tick(SETTLE);
    check("R7 bounce ignored", knob, model());
    // R7 long hold gives one step
    up = 1'b1; tick(200); up = 1'b0; tick(SETTLE);
    exp_lvl++;
    check("R7 no auto-repeat", knob, model());

    // R8 gpio mode
    gpio = 1'b1;
    press(0); press(1); press(2); press_pair(0);
    check("R8 gpio ignores buttons", knob, model());
    gpio = 1'b0;
    press(0); exp_lvl++;
    check("R8 buttons live again", knob, model());

    // R9 write, bit 6 forced low
    wdata = 8'hD7; wr = 1'b1; tick(1); wr = 1'b0;
    exp_mute = 1'b1; exp_lvl = 8'h17;
    check("R9 write bit6 cleared", knob, model());
    // R9 write on the cycle a step lands
    wdata = 8'h2A;
    up = 1'b1;
    repeat (2 * DEB + 1) @(posedge clk);
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    exp_mute = 1'b0; exp_lvl = 8'h2A;
    check("R9 write wins", knob, model());
    tick(SETTLE); up = 1'b0; tick(SETTLE);
    check("R9 step discarded", knob, model());

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule